// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller that sits next to an external integrating (dual-slope) analog front end. It drives the front end through a two-bit phase code and watches a single zero-crossing comparator line that comes back. On a start pulse it runs one conversion in a fixed order: auto-zero, then signal integrate, then reference de-integrate, then integrator zero.

The first two phases last a programmed number of clock cycles. The de-integrate phase is timed with a counter that stops on the comparator's falling edge. The count reached is the magnitude of the input. The sign comes from the comparator level at the end of integration. After integrator zero has finished, the block registers a signed result and marks it with a one-cycle valid pulse.

The comparator line is asynchronous. It passes through a two-flop synchronizer, so every comparator event is seen two cycles late. This delay is a fixed offset that the host can subtract. A programmable de-integrate limit stops a conversion whose comparator never falls; the result is then saturated and flagged as overrange. The phase-length inputs are 24 bits wide, so the integrate and auto-zero phases can be set to many line periods at typical clock rates.

Top module: `dslope_seq`

## Requirements
- R1: The phase code is `{phase_a_o, phase_b_o}`, with phase_a_o as the MSB. 2'b01 is auto-zero, 2'b10 is integrate, 2'b11 is de-integrate, and 2'b00 is integrator zero; 2'b00 is also driven while idle. While rst_n is low and after reset, the outputs are: code 2'b00, busy_o 0, valid_o 0, result_mag_o 0, result_neg_o 0 and overrange_o 0.
- R2: When start_i is high at a clock edge while idle, the next cycle is the first auto-zero cycle. The phases then follow the order auto-zero, integrate, de-integrate, integrator zero, idle. start_i has no effect while busy_o is high.
- R3: Auto-zero lasts az_len_i cycles; a value of 0 acts as 1. The comparator input has no effect on the block during auto-zero.
- R4: Integrate lasts int_len_i cycles, and de-integrate starts in the very next cycle. result_neg_o is the inverse of the synchronized comparator level in the last integrate cycle (1 = negative input).
- R5: De-integrate cycles are numbered from 0. If cmp_i falls (high to low) during de-integrate cycle j, the falling edge is detected in cycle j+2. The magnitude is then j+2, and de-integrate ends with that cycle.
- R6: If no synchronized falling edge has been seen by de-integrate cycle deint_lim_i, de-integrate ends after deint_lim_i+1 cycles. The magnitude is then all ones and overrange_o is 1. A falling edge detected exactly in cycle deint_lim_i gives magnitude deint_lim_i with overrange_o 0.
- R7: Integrator zero ends with the first of its cycles in which the synchronized comparator is low. If that has not happened after iz_max_i cycles (0 acts as 1), it ends anyway.
- R8: valid_o is high for exactly one cycle: the first idle cycle after integrator zero. In that same cycle result_mag_o, result_neg_o and overrange_o take their new values, and they hold them until the next completed conversion.
- R9: Pulling rst_n low in the middle of a conversion aborts it. At the next clock edge the block is idle with phase code 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a conversion when sampled high while idle |
| az_len_i | input | TIME_W | Auto-zero length in cycles |
| int_len_i | input | TIME_W | Integrate length in cycles |
| iz_max_i | input | TIME_W | Upper bound on integrator-zero length in cycles |
| deint_lim_i | input | MAG_W | Last de-integrate cycle index before overrange |
| cmp_i | input | 1 | Asynchronous zero-crossing comparator line |
| phase_a_o | output | 1 | Phase code MSB |
| phase_b_o | output | 1 | Phase code LSB |
| busy_o | output | 1 | High from the first auto-zero cycle through the last integrator-zero cycle |
| valid_o | output | 1 | One-cycle strobe that marks a new result |
| result_mag_o | output | MAG_W | De-integration count (magnitude) |
| result_neg_o | output | 1 | Sign of the input, 1 = negative |
| overrange_o | output | 1 | Set when the de-integrate limit was reached |

## Verification
Conversions are run for both comparator polarities during integration. Falling edges are placed at the earliest possible de-integrate cycle, in mid-range, exactly at the limit and one cycle past it. These separate a correct count from off-by-one sync latency and a wrong limit compare. Runs with no falling edge at all are split by how long the comparator stays high during integrator zero, which tells an exit on a low level apart from an exit on the iz_max_i bound. A toggling comparator during auto-zero, start held high for a whole conversion, zero-length auto-zero, and a reset in mid-conversion cover the ignore and boundary rules.

// File: rtl/dslope_pkg.sv
// Shared definitions for the dual-slope sequencer.
// Assumes: phase code bit 1 drives the front end's MSB control line.
package dslope_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AZ,
        ST_INT,
        ST_DEINT,
        ST_IZ
    } seq_state_t;

    localparam logic [1:0] PH_IZERO = 2'b00;
    localparam logic [1:0] PH_AZERO = 2'b01;
    localparam logic [1:0] PH_INTEG = 2'b10;
    localparam logic [1:0] PH_DEINT = 2'b11;

endpackage

// File: rtl/dslope_cmp_sync.sv
// Synchronizes the asynchronous comparator line and flags falling edges.
// Assumes: STAGES >= 2; reset value is low, so a line held high from reset
// produces no false falling edge.
module dslope_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_async_i,
    output logic level_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], cmp_async_i};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/dslope_phase_timer.sv
// Counts cycles spent in the current phase and flags its last cycle.
// Assumes: clear_i is high in the cycle before a phase starts, and len_i is
// stable during the phase; a length of 0 acts as 1.
module dslope_phase_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic [W-1:0] len_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_plus1;

    assign cnt_plus1 = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign last_o    = cnt_plus1 >= {1'b0, len_i};

    // Advance the cycle count; restart on clear, hold once the end is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (!last_o)      cnt_q <= cnt_plus1[W-1:0];
    end

endmodule

// File: rtl/dslope_deint_counter.sv
// Measures de-integrate time: counts from 0 at the first de-integrate cycle,
// stops on a comparator falling edge or at the programmed limit.
// Assumes: lim_i is stable while run_i is high.
module dslope_deint_counter #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         fall_i,
    input  logic [W-1:0] lim_i,
    output logic         stop_o,
    output logic         ovr_o,
    output logic [W-1:0] mag_o
);

    logic [W-1:0] cnt_q;
    logic         at_lim;

    assign at_lim = (cnt_q == lim_i);
    assign stop_o = run_i & (fall_i | at_lim);
    assign ovr_o  = ~fall_i & at_lim;
    assign mag_o  = fall_i ? cnt_q : {W{1'b1}};

    // Count de-integrate cycles; cleared whenever the phase is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (!stop_o)     cnt_q <= cnt_q + 1'b1;
    end

    // The count never passes the limit while the phase runs.
    p_cnt_within_lim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= lim_i));

endmodule

// File: rtl/dslope_seq.sv
// Dual-slope conversion sequencer: steps an external integrating front end
// through auto-zero, integrate, de-integrate and integrator zero, times the
// de-integration against the comparator and presents a signed result.
// Assumes: configuration inputs are stable while busy_o is high; cmp_i is
// asynchronous and seen SYNC_STAGES cycles late.
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int MAG_W       = 17,
    parameter int TIME_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TIME_W-1:0] az_len_i,
    input  logic [TIME_W-1:0] int_len_i,
    input  logic [TIME_W-1:0] iz_max_i,
    input  logic [MAG_W-1:0]  deint_lim_i,
    input  logic              cmp_i,
    output logic              phase_a_o,
    output logic              phase_b_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [MAG_W-1:0]  result_mag_o,
    output logic              result_neg_o,
    output logic              overrange_o
);

    seq_state_t        state_q, state_d;
    logic              cmp_lvl, cmp_fall;
    logic              tmr_last, tmr_clear;
    logic [TIME_W-1:0] tmr_len;
    logic              dc_stop, dc_ovr;
    logic [MAG_W-1:0]  dc_mag;
    logic [MAG_W-1:0]  mag_hold_q;
    logic              neg_hold_q, ovr_hold_q;
    logic              advance;
    logic [1:0]        code;

    dslope_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cmp_async_i(cmp_i),
        .level_o(cmp_lvl), .fall_o(cmp_fall)
    );

    dslope_phase_timer #(.W(TIME_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear_i(tmr_clear),
        .len_i(tmr_len), .last_o(tmr_last)
    );

    dslope_deint_counter #(.W(MAG_W)) u_deint (
        .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_DEINT),
        .fall_i(cmp_fall), .lim_i(deint_lim_i),
        .stop_o(dc_stop), .ovr_o(dc_ovr), .mag_o(dc_mag)
    );

    // Pick the length the phase timer compares against.
    always_comb begin
        unique case (state_q)
            ST_AZ:   tmr_len = az_len_i;
            ST_INT:  tmr_len = int_len_i;
            default: tmr_len = iz_max_i;
        endcase
    end

    // Next-state logic in the fixed four-phase order.
    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (start_i) begin state_d = ST_AZ; advance = 1'b1; end
            ST_AZ:    if (tmr_last) begin state_d = ST_INT; advance = 1'b1; end
            ST_INT:   if (tmr_last) begin state_d = ST_DEINT; advance = 1'b1; end
            ST_DEINT: if (dc_stop) begin state_d = ST_IZ; advance = 1'b1; end
            ST_IZ:    if (!cmp_lvl || tmr_last) begin state_d = ST_IDLE; advance = 1'b1; end
            default:  begin state_d = ST_IDLE; advance = 1'b1; end
        endcase
    end

    assign tmr_clear = advance | (state_q == ST_IDLE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture sign at the end of integrate and magnitude at the end of de-integrate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_hold_q <= 1'b0;
            mag_hold_q <= '0;
            ovr_hold_q <= 1'b0;
        end else begin
            if (state_q == ST_INT && tmr_last) neg_hold_q <= ~cmp_lvl;
            if (state_q == ST_DEINT && dc_stop) begin
                mag_hold_q <= dc_mag;
                ovr_hold_q <= dc_ovr;
            end
        end
    end

    // Publish the result and pulse valid when integrator zero finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o      <= 1'b0;
            result_mag_o <= '0;
            result_neg_o <= 1'b0;
            overrange_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (state_q == ST_IZ && advance) begin
                valid_o      <= 1'b1;
                result_mag_o <= mag_hold_q;
                result_neg_o <= neg_hold_q;
                overrange_o  <= ovr_hold_q;
            end
        end
    end

    // Decode the phase code driven to the front end.
    always_comb begin
        unique case (state_q)
            ST_AZ:    code = PH_AZERO;
            ST_INT:   code = PH_INTEG;
            ST_DEINT: code = PH_DEINT;
            default:  code = PH_IZERO;
        endcase
    end

    assign phase_a_o = code[1];
    assign phase_b_o = code[0];
    assign busy_o    = (state_q != ST_IDLE);

    // Idle always drives the integrator-zero code.
    p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ({phase_a_o, phase_b_o} == PH_IZERO));

    // A start while idle opens auto-zero in the next cycle.
    p_start_opens_az_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && {phase_a_o, phase_b_o} == PH_AZERO));

    // Phase order: auto-zero may only continue or go to integrate.
    p_order_az_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && {phase_a_o, phase_b_o} == PH_AZERO) |=>
        ({phase_a_o, phase_b_o} == PH_AZERO || {phase_a_o, phase_b_o} == PH_INTEG));

    // Integrate is followed directly by de-integrate.
    p_order_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({phase_a_o, phase_b_o} == PH_INTEG) |=>
        ({phase_a_o, phase_b_o} == PH_INTEG || {phase_a_o, phase_b_o} == PH_DEINT));

    // De-integrate is followed by integrator zero, which keeps busy high.
    p_order_deint_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({phase_a_o, phase_b_o} == PH_DEINT) |=>
        (busy_o && ({phase_a_o, phase_b_o} == PH_DEINT || {phase_a_o, phase_b_o} == PH_IZERO)));

    // Overrange results are saturated.
    p_ovr_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && overrange_o) |-> (&result_mag_o));

    // A low synchronized comparator ends integrator zero.
    p_iz_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IZ && !cmp_lvl) |=> (!busy_o && valid_o));

    // Valid is a single-cycle pulse and results hold afterwards.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (!valid_o && $stable(result_mag_o) && $stable(result_neg_o)));

endmodule

// File: tb/dslope_seq_bench.sv
// Self-checking bench for dslope_seq: vector table walked by one loop,
// then directed reset and abort tests.
module dslope_seq_bench;

    localparam int MAG_W  = 17;
    localparam int TIME_W = 24;
    localparam int ONES   = (1 << MAG_W) - 1;
    localparam int NEVER  = 100000;

    // Columns: az, int, lim, positive, drop cycle, iz high cycles, iz max, hold start
    localparam int NVEC = 10;
    localparam int VEC [NVEC][8] = '{
        '{4, 5, 100, 1, 10,    0,  8, 0},
        '{3, 8, 100, 0, 5,     0,  8, 0},
        '{6, 3, 200, 1, 0,     0,  8, 0},
        '{5, 4, 20,  1, 18,    0,  8, 0},
        '{5, 4, 20,  0, 19,    0,  8, 0},
        '{4, 4, 30,  1, NEVER, 2, 16, 0},
        '{4, 4, 30,  0, NEVER, 20, 6, 0},
        '{1, 3, 50,  1, 7,     0,  4, 0},
        '{0, 3, 50,  0, 9,     0,  4, 0},
        '{3, 6, 60,  0, 12,    0,  8, 1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [TIME_W-1:0] az_len_i = '0;
    logic [TIME_W-1:0] int_len_i = '0;
    logic [TIME_W-1:0] iz_max_i = '0;
    logic [MAG_W-1:0]  deint_lim_i = '0;
    logic              cmp_i = 1'b0;
    logic              phase_a_o, phase_b_o, busy_o, valid_o;
    logic [MAG_W-1:0]  result_mag_o;
    logic              result_neg_o, overrange_o;

    int n_chk = 0;
    int n_fail = 0;

    dslope_seq u_dslope_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .az_len_i(az_len_i), .int_len_i(int_len_i), .iz_max_i(iz_max_i),
        .deint_lim_i(deint_lim_i), .cmp_i(cmp_i),
        .phase_a_o(phase_a_o), .phase_b_o(phase_b_o), .busy_o(busy_o),
        .valid_o(valid_o), .result_mag_o(result_mag_o),
        .result_neg_o(result_neg_o), .overrange_o(overrange_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion; inputs driven and outputs sampled at falling edges.
    task automatic run_conv(input int az, input int intl, input int lim,
                            input int pos, input int drop, input int izh,
                            input int izmax, input int hold);
        int naz = 0, nint = 0, nde = 0, niz = 0, guard = 0;
        int eaz, ede, emag, eovr, eiz;
        logic [MAG_W-1:0] mag_seen;
        az_len_i = TIME_W'(az); int_len_i = TIME_W'(intl);
        iz_max_i = TIME_W'(izmax); deint_lim_i = MAG_W'(lim);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = hold[0];
        forever begin
            if (!busy_o || guard > 5000) break;
            guard++;
            case ({phase_a_o, phase_b_o})
                2'b01: begin naz++; cmp_i = naz[0]; end
                2'b10: begin nint++; cmp_i = pos[0]; end
                2'b11: begin cmp_i = (nde < drop); nde++; end
                default: begin cmp_i = (niz < izh); niz++; end
            endcase
            @(negedge clk);
        end
        start_i = 1'b0;
        eaz = (az == 0) ? 1 : az;
        if (drop + 2 <= lim) begin
            ede = drop + 3; emag = drop + 2; eovr = 0;
        end else begin
            ede = lim + 1; emag = ONES; eovr = 1;
        end
        eiz = 0;
        for (int c = 0; c < 100000; c++) begin
            int t = ede + c - 2;
            bit low = (t < ede) ? (t >= drop) : ((t - ede) >= izh);
            if (low || (c + 1) >= izmax) begin eiz = c + 1; break; end
        end
        chk("R2 start ignored while busy / R3 auto-zero length", naz, eaz);
        chk("R4 integrate length", nint, intl);
        chk("R5/R6 de-integrate length", nde, ede);
        chk("R7 integrator zero length", niz, eiz);
        chk("R8 valid in first idle cycle", int'(valid_o), 1);
        chk("R5/R6 magnitude", int'(result_mag_o), emag);
        chk("R4 sign", int'(result_neg_o), pos == 0 ? 1 : 0);
        chk("R6 overrange flag", int'(overrange_o), eovr);
        mag_seen = result_mag_o;
        @(negedge clk);
        chk("R8 valid one cycle", int'(valid_o), 0);
        chk("R8 result held", int'(result_mag_o), int'(mag_seen));
        chk("R2 no restart after held start", int'(busy_o), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset code", int'({phase_a_o, phase_b_o}), 0);
        chk("R1 reset busy", int'(busy_o), 0);
        chk("R1 reset valid", int'(valid_o), 0);
        chk("R1 reset result", int'(result_mag_o), 0);
        chk("R1 reset overrange", int'(overrange_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_conv(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                     VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7]);
        end

        // R9 abort in mid-conversion
        az_len_i = TIME_W'(50);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R1 auto-zero code after start", int'({phase_a_o, phase_b_o}), 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 abort busy", int'(busy_o), 0);
        chk("R9 abort code", int'({phase_a_o, phase_b_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 stays idle", int'(busy_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule